// File: doc/BRIEF.md
# Breakpoint Exception Entry Unit

This unit reacts to a decoded software breakpoint in a small 32-bit processor core. When the breakpoint strobe arrives, it takes one of two paths. If debug override is enabled, it leaves all architectural state alone, sends a single-cycle request to the external debugger and freezes the program counter. The freeze lasts until the debugger returns a resume address. Otherwise it performs a prefetch-abort style entry. That entry rewrites the status word, saves the old status and a return address into the abort-mode banked registers, and redirects the PC to the low or high abort vector.

Every result is registered and appears one clock after the strobe, as write-enable/data pairs that the register file and fetch unit consume. The 8-bit immediate carried by the breakpoint instruction is captured only as a tag for the debugger. It never influences the architectural writes.

Top module: `bkpt_entry_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we, dbg_req and fetch_hold are all low.
- R2: On a breakpoint taken as an exception, the cycle after the strobe has psr_wr_en high. In psr_next, bits [4:0] are 0b10111 and bit 5 is 0. Bit 6 equals bit 6 of the old status word, bit 7 is 1, and bits [31:8] are copied unchanged.
- R3: On a breakpoint taken as an exception, the cycle after the strobe has pc_wr_en high. pc_next is 0xFFFF000C when hivec_cfg was 1 and 0x0000000C when it was 0.
- R4: On a breakpoint taken as an exception, lr_abt_we and spsr_abt_we are high in the same cycle as psr_wr_en. lr_abt_wdata equals the breakpoint address plus 4, modulo 2^32, and spsr_abt_wdata equals the old status word.
- R5: On a breakpoint with dbg_override_en high, the next cycle has dbg_req high and pc_wr_en, psr_wr_en, lr_abt_we and spsr_abt_we all low. dbg_req stays high for exactly one cycle.
- R6: After an overridden breakpoint, fetch_hold is high and pc_wr_en stays low until dbg_resume_valid is seen. In the cycle after that, pc_wr_en is high, pc_next equals dbg_resume_pc and fetch_hold is low.
- R7: bkpt_imm has no effect on any architectural write. dbg_tag holds the immediate of the last accepted breakpoint.
- R8: A breakpoint strobe that arrives while fetch_hold is high is dropped and produces no write and no dbg_req. This holds even when dbg_resume_valid is high in the same cycle, in which case the resume alone is performed.
- R9: dbg_resume_valid has no effect while fetch_hold is low.
- R10: Every write enable and dbg_req is a single-cycle pulse. With no new strobe or resume, all of them are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bkpt_valid | input | 1 | Breakpoint decoded this cycle |
| bkpt_pc | input | 32 | Address of the breakpoint instruction |
| bkpt_imm | input | 8 | Immediate field of the breakpoint instruction |
| cur_psr | input | 32 | Current program status word |
| dbg_override_en | input | 1 | Debug hardware claims breakpoints |
| hivec_cfg | input | 1 | Selects the high exception vector base |
| dbg_resume_valid | input | 1 | Debugger supplies a resume address |
| dbg_resume_pc | input | 32 | Resume address from the debugger |
| pc_wr_en | output | 1 | Load pc_next into the PC |
| pc_next | output | 32 | New PC value |
| psr_wr_en | output | 1 | Load psr_next into the status register |
| psr_next | output | 32 | New status word |
| lr_abt_we | output | 1 | Write abort-mode link register |
| lr_abt_wdata | output | 32 | Abort-mode link register data |
| spsr_abt_we | output | 1 | Write abort-mode saved status register |
| spsr_abt_wdata | output | 32 | Abort-mode saved status data |
| dbg_req | output | 1 | One-cycle request to the debug hardware |
| dbg_tag | output | 8 | Immediate of the last accepted breakpoint |
| fetch_hold | output | 1 | PC frozen awaiting debugger resume |

## Verification
Two functions can land in the same cycle: a resume from the debugger and a new breakpoint strobe. Both occur while the unit is halted. The bench provokes this by raising both strobes at one clock edge. It judges the outcome by requiring a PC write of the resume address, the release of the hold, and the absence of any status, banked-register or debug-request activity from the dropped breakpoint. Random exception entries with random status words, addresses, immediates and vector choices are compared against bench-computed status and vector values. These are mixed with address wrap-around and both settings of the fast-interrupt mask bit.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned MODE_W    = 5;
  localparam logic [MODE_W-1:0] ABORT_MODE = 5'b10111;
  localparam int unsigned STATE_BIT = 5;
  localparam int unsigned FIQ_BIT   = 6;
  localparam int unsigned IRQ_BIT   = 7;

  typedef struct packed {
    logic pc_we;
    logic psr_we;
    logic bank_we;
    logic dbg_req;
  } bkpt_ctl_t;
endpackage

// File: rtl/bkpt_psr_xform.sv
module bkpt_psr_xform
  import bkpt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] psr_i,
  output logic [W-1:0] psr_o
);
  always_comb begin
    psr_o                  = psr_i;
    psr_o[MODE_W-1:0]      = ABORT_MODE;
    psr_o[STATE_BIT]       = 1'b0;
    psr_o[IRQ_BIT]         = 1'b1;
    // the fast-interrupt mask bit passes through untouched
  end
endmodule

// File: rtl/bkpt_vec_sel.sv
module bkpt_vec_sel #(
  parameter int unsigned W          = 32,
  parameter logic [31:0] HI_BASE    = 32'hFFFF_0000,
  parameter logic [31:0] LO_BASE    = 32'h0000_0000,
  parameter int unsigned VEC_OFS    = 12,
  parameter bit          HAS_HIVEC  = 1'b1
) (
  input  logic         hivec_i,
  output logic [W-1:0] vec_o
);
  localparam logic [W-1:0] HI_VEC = W'(HI_BASE) + W'(VEC_OFS);
  localparam logic [W-1:0] LO_VEC = W'(LO_BASE) + W'(VEC_OFS);

  generate
    if (HAS_HIVEC) begin : g_sel
      assign vec_o = hivec_i ? HI_VEC : LO_VEC;
    end else begin : g_fixed
      logic unused_hi;
      assign unused_hi = hivec_i;
      assign vec_o     = LO_VEC;
    end
  endgenerate
endmodule

// File: rtl/bkpt_dbg_ctrl.sv
module bkpt_dbg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bkpt_i,
  input  logic override_i,
  input  logic resume_i,
  output logic take_exc_o,
  output logic take_dbg_o,
  output logic do_resume_o,
  output logic halted_o
);
  logic halted_q, halted_d;
  logic accept;

  always_comb begin
    accept      = bkpt_i & ~halted_q;
    take_exc_o  = accept & ~override_i;
    take_dbg_o  = accept & override_i;
    do_resume_o = halted_q & resume_i;
    halted_d    = halted_q;
    if (do_resume_o)     halted_d = 1'b0;
    else if (take_dbg_o) halted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else        halted_q <= halted_d;
  end

  assign halted_o = halted_q;
endmodule

// File: rtl/bkpt_entry_unit.sv
module bkpt_entry_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned IMM_W     = 8,
  parameter int unsigned LINK_OFS  = 4,
  parameter logic [31:0] HI_BASE   = 32'hFFFF_0000,
  parameter int unsigned VEC_OFS   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkpt_valid,
  input  logic [XLEN-1:0]  bkpt_pc,
  input  logic [IMM_W-1:0] bkpt_imm,
  input  logic [XLEN-1:0]  cur_psr,
  input  logic             dbg_override_en,
  input  logic             hivec_cfg,
  input  logic             dbg_resume_valid,
  input  logic [XLEN-1:0]  dbg_resume_pc,
  output logic             pc_wr_en,
  output logic [XLEN-1:0]  pc_next,
  output logic             psr_wr_en,
  output logic [XLEN-1:0]  psr_next,
  output logic             lr_abt_we,
  output logic [XLEN-1:0]  lr_abt_wdata,
  output logic             spsr_abt_we,
  output logic [XLEN-1:0]  spsr_abt_wdata,
  output logic             dbg_req,
  output logic [IMM_W-1:0] dbg_tag,
  output logic             fetch_hold
);
  logic            take_exc, take_dbg, do_resume, halted;
  logic [XLEN-1:0] psr_abt, vec_addr;
  logic [XLEN-1:0] pc_d, lr_d;
  bkpt_ctl_t       ctl_d, ctl_q;

  bkpt_dbg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bkpt_i      (bkpt_valid),
    .override_i  (dbg_override_en),
    .resume_i    (dbg_resume_valid),
    .take_exc_o  (take_exc),
    .take_dbg_o  (take_dbg),
    .do_resume_o (do_resume),
    .halted_o    (halted)
  );

  bkpt_psr_xform #(.W(XLEN)) u_psr (
    .psr_i (cur_psr),
    .psr_o (psr_abt)
  );

  bkpt_vec_sel #(
    .W         (XLEN),
    .HI_BASE   (HI_BASE),
    .VEC_OFS   (VEC_OFS),
    .HAS_HIVEC (1'b1)
  ) u_vec (
    .hivec_i (hivec_cfg),
    .vec_o   (vec_addr)
  );

  // next-state
  always_comb begin
    ctl_d.pc_we   = take_exc | do_resume;
    ctl_d.psr_we  = take_exc;
    ctl_d.bank_we = take_exc;
    ctl_d.dbg_req = take_dbg;
    pc_d          = take_exc ? vec_addr : dbg_resume_pc;
    lr_d          = bkpt_pc + XLEN'(LINK_OFS);
  end

  // control pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // data registers with explicit load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pc_next <= '0;
    else if (ctl_d.pc_we) pc_next <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_next       <= '0;
      lr_abt_wdata   <= '0;
      spsr_abt_wdata <= '0;
    end else if (take_exc) begin
      psr_next       <= psr_abt;
      lr_abt_wdata   <= lr_d;
      spsr_abt_wdata <= cur_psr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dbg_tag <= '0;
    else if (take_exc | take_dbg)  dbg_tag <= bkpt_imm;
  end

  assign pc_wr_en    = ctl_q.pc_we;
  assign psr_wr_en   = ctl_q.psr_we;
  assign lr_abt_we   = ctl_q.bank_we;
  assign spsr_abt_we = ctl_q.bank_we;
  assign dbg_req     = ctl_q.dbg_req;
  assign fetch_hold  = halted;
endmodule

// File: rtl/bkpt_entry_unit_chk.sv
module bkpt_entry_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bkpt_valid,
  input logic [31:0] bkpt_pc,
  input logic [31:0] cur_psr,
  input logic        dbg_override_en,
  input logic        hivec_cfg,
  input logic        dbg_resume_valid,
  input logic [31:0] dbg_resume_pc,
  input logic        pc_wr_en,
  input logic [31:0] pc_next,
  input logic        psr_wr_en,
  input logic [31:0] psr_next,
  input logic        lr_abt_we,
  input logic [31:0] lr_abt_wdata,
  input logic        spsr_abt_we,
  input logic [31:0] spsr_abt_wdata,
  input logic        dbg_req,
  input logic        fetch_hold
);
  always @(posedge clk) begin
    if (!rst_n)
      AST_RESET_QUIET: assert (!pc_wr_en && !psr_wr_en && !lr_abt_we && !spsr_abt_we && !dbg_req && !fetch_hold); // R1
  end

  AST_ABORT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_valid && !dbg_override_en && !fetch_hold) |=>
      (psr_wr_en && psr_next[4:0] == 5'b10111 && !psr_next[5] && psr_next[7] &&
       psr_next[6] == $past(cur_psr[6]) && psr_next[31:8] == $past(cur_psr[31:8]))); // R2

  AST_VECTOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_valid && !dbg_override_en && !fetch_hold) |=>
      (pc_wr_en && pc_next == ($past(hivec_cfg) ? 32'hFFFF000C : 32'h0000000C))); // R3

  AST_BANK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_valid && !dbg_override_en && !fetch_hold) |=>
      (lr_abt_we && spsr_abt_we && lr_abt_wdata == $past(bkpt_pc) + 32'd4 &&
       spsr_abt_wdata == $past(cur_psr))); // R4

  AST_OVERRIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_valid && dbg_override_en && !fetch_hold) |=>
      (dbg_req && !pc_wr_en && !psr_wr_en && !lr_abt_we && !spsr_abt_we)); // R5

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |=> !dbg_req); // R5

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hold && !dbg_resume_valid) |=> (fetch_hold && !pc_wr_en && !psr_wr_en && !dbg_req)); // R8

  AST_RESUME_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hold && dbg_resume_valid) |=>
      (pc_wr_en && !fetch_hold && !psr_wr_en && !dbg_req && pc_next == $past(dbg_resume_pc))); // R6

  AST_IDLE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_hold && !bkpt_valid) |=> (!pc_wr_en && !psr_wr_en && !dbg_req)); // R9

  AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({psr_wr_en, dbg_req})); // R10
endmodule

bind bkpt_entry_unit bkpt_entry_unit_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bkpt_valid     (bkpt_valid),
  .bkpt_pc        (bkpt_pc),
  .cur_psr        (cur_psr),
  .dbg_override_en(dbg_override_en),
  .hivec_cfg      (hivec_cfg),
  .dbg_resume_valid(dbg_resume_valid),
  .dbg_resume_pc  (dbg_resume_pc),
  .pc_wr_en       (pc_wr_en),
  .pc_next        (pc_next),
  .psr_wr_en      (psr_wr_en),
  .psr_next       (psr_next),
  .lr_abt_we      (lr_abt_we),
  .lr_abt_wdata   (lr_abt_wdata),
  .spsr_abt_we    (spsr_abt_we),
  .spsr_abt_wdata (spsr_abt_wdata),
  .dbg_req        (dbg_req),
  .fetch_hold     (fetch_hold)
);

// File: tb/bkpt_entry_unit_test.sv
`timescale 1ns/1ps
module bkpt_entry_unit_test;
  logic        clk;
  logic        rst_n;
  logic        bkpt_valid;
  logic [31:0] bkpt_pc;
  logic [7:0]  bkpt_imm;
  logic [31:0] cur_psr;
  logic        dbg_override_en;
  logic        hivec_cfg;
  logic        dbg_resume_valid;
  logic [31:0] dbg_resume_pc;
  logic        pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we, dbg_req, fetch_hold;
  logic [31:0] pc_next, psr_next, lr_abt_wdata, spsr_abt_wdata;
  logic [7:0]  dbg_tag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  bkpt_entry_unit uut (
    .clk(clk), .rst_n(rst_n), .bkpt_valid(bkpt_valid), .bkpt_pc(bkpt_pc),
    .bkpt_imm(bkpt_imm), .cur_psr(cur_psr), .dbg_override_en(dbg_override_en),
    .hivec_cfg(hivec_cfg), .dbg_resume_valid(dbg_resume_valid),
    .dbg_resume_pc(dbg_resume_pc), .pc_wr_en(pc_wr_en), .pc_next(pc_next),
    .psr_wr_en(psr_wr_en), .psr_next(psr_next), .lr_abt_we(lr_abt_we),
    .lr_abt_wdata(lr_abt_wdata), .spsr_abt_we(spsr_abt_we),
    .spsr_abt_wdata(spsr_abt_wdata), .dbg_req(dbg_req), .dbg_tag(dbg_tag),
    .fetch_hold(fetch_hold)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] exp_psr(input logic [31:0] p);
    logic [31:0] e = p;
    e[4:0] = 5'b10111;
    e[5]   = 1'b0;
    e[7]   = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] exp_vec(input logic hi);
    return hi ? 32'hFFFF000C : 32'h0000000C;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cycle(input logic bv, input logic [31:0] pc, input logic [31:0] psr,
                       input logic ovr, input logic hi, input logic [7:0] imm,
                       input logic rv, input logic [31:0] rpc);
    bkpt_valid = bv; bkpt_pc = pc; cur_psr = psr; dbg_override_en = ovr;
    hivec_cfg = hi; bkpt_imm = imm; dbg_resume_valid = rv; dbg_resume_pc = rpc;
    @(negedge clk);
    bkpt_valid = 1'b0; dbg_resume_valid = 1'b0;
  endtask

  task automatic idle();
    cycle(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 8'h00, 1'b0, 32'h0);
  endtask

  task automatic exc_case(input logic [31:0] pc, input logic [31:0] psr,
                          input logic hi, input logic [7:0] imm);
    cycle(1'b1, pc, psr, 1'b0, hi, imm, 1'b0, 32'h0);
    chk("R2 psr_wr_en", 32'(psr_wr_en), 32'd1);
    chk("R2 psr_next", psr_next, exp_psr(psr));
    chk("R3 pc_wr_en", 32'(pc_wr_en), 32'd1);
    chk("R3 pc_next", pc_next, exp_vec(hi));
    chk("R4 bank enables", {30'd0, lr_abt_we, spsr_abt_we}, 32'd3);
    chk("R4 lr_abt_wdata", lr_abt_wdata, pc + 32'd4);
    chk("R4 spsr_abt_wdata", spsr_abt_wdata, psr);
    chk("R5 no dbg_req on exception", 32'(dbg_req), 32'd0);
    chk("R7 dbg_tag", 32'(dbg_tag), 32'(imm));
    idle();
    chk("R10 pulses drop", {26'd0, pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we, dbg_req, fetch_hold}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rpc, pc_r, psr_r;
    void'($urandom(32'h5EED_0B17));
    rst_n = 1'b0;
    bkpt_valid = 1'b0; bkpt_pc = '0; bkpt_imm = '0; cur_psr = '0;
    dbg_override_en = 1'b0; hivec_cfg = 1'b0; dbg_resume_valid = 1'b0; dbg_resume_pc = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {26'd0, pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we, dbg_req, fetch_hold}, 32'd0);
    rst_n = 1'b1;
    idle();
    chk("R1 after reset", {26'd0, pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we, dbg_req, fetch_hold}, 32'd0);

    // R9: resume while not halted
    cycle(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 8'h0, 1'b1, 32'h1234_5678);
    chk("R9 stray resume", {30'd0, pc_wr_en, fetch_hold}, 32'd0);

    // directed exception corners: both vectors, both fast-mask values, wrap
    exc_case(32'h0000_1000, 32'h0000_0010, 1'b0, 8'hAA);
    exc_case(32'h0000_1000, 32'h0000_0010, 1'b1, 8'h55);
    exc_case(32'hFFFF_FFFC, 32'hF000_0070, 1'b1, 8'h00);
    exc_case(32'h8000_0002, 32'h0000_00FF, 1'b0, 8'hFF);
    exc_case(32'h8000_0002, 32'h0000_00BF, 1'b0, 8'h01);

    // random exception entries
    for (int i = 0; i < 200; i++) begin
      pc_r  = $urandom & 32'hFFFF_FFFE;
      psr_r = $urandom;
      exc_case(pc_r, psr_r, 1'($urandom), 8'($urandom));
    end

    // debug override and halt handling
    for (int k = 0; k < 20; k++) begin
      rpc = $urandom & 32'hFFFF_FFFE;
      cycle(1'b1, 32'h0000_2000, 32'h0000_001F, 1'b1, 1'($urandom), 8'(k + 8'h30), 1'b0, 32'h0);
      chk("R5 dbg_req", 32'(dbg_req), 32'd1);
      chk("R5 no writes", {28'd0, pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we}, 32'd0);
      chk("R6 hold", 32'(fetch_hold), 32'd1);
      chk("R7 tag on override", 32'(dbg_tag), 32'(k + 8'h30));
      idle();
      chk("R5 single pulse", 32'(dbg_req), 32'd0);
      chk("R6 hold kept", {30'd0, fetch_hold, pc_wr_en}, 32'd2);
      // R8: strobe while halted is dropped
      cycle(1'b1, 32'h0000_3000, 32'h0000_0013, 1'(k & 1), 1'b0, 8'hEE, 1'b0, 32'h0);
      chk("R8 dropped strobe", {26'd0, pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we, dbg_req, fetch_hold}, 32'd1);
      chk("R8 tag unchanged", 32'(dbg_tag), 32'(k + 8'h30));
      // R8/R6: resume and strobe in the same cycle
      cycle(1'b1, 32'h0000_4000, 32'h0000_0013, 1'(k & 1), 1'b1, 8'hDD, 1'b1, rpc);
      chk("R6 resume we", {26'd0, pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we, dbg_req, fetch_hold}, 32'h20);
      chk("R6 resume pc", pc_next, rpc);
      idle();
      chk("R10 idle after resume", {26'd0, pc_wr_en, psr_wr_en, lr_abt_we, spsr_abt_we, dbg_req, fetch_hold}, 32'd0);
    end

    finish_run();
  end
endmodule